// File: doc/BRIEF.md
# Dithered Word-Length Reducer

This block shortens a stream of signed high-resolution audio samples to a narrower word, 24 bits down to 16 bits by default. Before the low bits are dropped, it adds a zero-mean dither with a triangular probability density to the wide value. The rounded result is then saturated to the output range. The triangular density comes from adding two uniform values. Each uniform value is taken from its own pseudorandom shift register, and the two registers use different feedback polynomials, so the two sources are uncorrelated.

Samples arrive on a valid/ready input. Each accepted sample yields one reduced word one cycle later, flagged by an output valid. A control input turns the dither on or off. With dither off, the block rounds to nearest and saturates. A seed-load input reloads both generators. A zero seed is replaced by a fixed non-zero constant, so neither register can lock up.

Top module: `dither_requant`

## Requirements
- R1: While rst_ni is low, out_valid_o is 0 and out_data_o is 0. Generator A resets to 32'h0000_0001 and generator B resets to 32'h2545_F491.
- R2: in_ready_o equals the inverse of seed_load_i. A sample is accepted when in_valid_i and in_ready_o are both high. out_valid_o is high in the cycle after an acceptance and low in every other cycle.
- R3: When dither_en_i is 0 at acceptance, out_data_o equals sat(floor((x + 128) / 256)), where x is the signed input.
- R4: Results above 32767 are output as 32767 and results below -32768 are output as -32768. They never wrap, so input 24'h7FFFFF gives 16'h7FFF.
- R5: When dither_en_i is 1 at acceptance, out_data_o equals sat(floor((x + ca + cb + 128) / 256)). Here ca = (A[7:0] >> 1) - 64 and cb = (B[7:0] >> 1) - 64, using the generator states held before the advance caused by that acceptance. Each component spans half an output LSB and the sum spans one output LSB.
- R6: On each acceptance, generator A shifts left by one bit and takes the XOR of its bits 31, 21, 1 and 0 into bit 0.
- R7: On each acceptance, generator B shifts left by one bit and takes the XOR of its bits 31, 6, 4, 2, 1 and 0 into bit 0.
- R8: A cycle with seed_load_i high loads seed_a_i into A and seed_b_i into B. A zero seed is replaced by the reset constant of that generator.
- R9: Neither generator changes state in a cycle with neither an acceptance nor a seed load.
- R10: Every output with dither on is either sat(floor(x/256)) or sat(floor(x/256) + 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input sample is valid |
| in_ready_o | output | 1 | Block can accept a sample |
| in_data_i | input | 24 | Signed wide input sample |
| dither_en_i | input | 1 | Adds triangular dither when 1 |
| seed_load_i | input | 1 | Reloads both generators |
| seed_a_i | input | 32 | Seed for generator A |
| seed_b_i | input | 32 | Seed for generator B |
| out_valid_o | output | 1 | Reduced word is valid |
| out_data_o | output | 16 | Signed reduced word |

## Verification
The undithered path is swept across the whole signed input range with a fixed stride. Every input within a few codes of the rounding midpoint and the saturation limits is also applied. Together these separate round-to-nearest from truncation and saturation from wrap-around. The dithered path is swept with a bench model of both shift registers. The model tells a correct dither scale, centring and per-generator polynomial apart from a swapped, shared or unscaled source. Stalls, seed reloads and zero seeds then show that the generators advance only on accepted samples and never stay at zero.

// File: rtl/dither_requant_pkg.sv
package dither_requant_pkg;
  localparam int unsigned GEN_W = 32;
  localparam int unsigned N_GEN = 2;
  // feedback masks, bit i set means state bit i enters the XOR
  localparam logic [N_GEN-1:0][GEN_W-1:0] GEN_TAPS = {32'h8000_0057, 32'h8020_0003};
  localparam logic [N_GEN-1:0][GEN_W-1:0] GEN_INIT = {32'h2545_F491, 32'h0000_0001};
endpackage

// File: rtl/prng_shift.sv
module prng_shift #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] TAPS = '1,
  parameter logic [W-1:0] INIT = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] seed_i,
  input  logic         adv_i,
  output logic [W-1:0] state_o
);
  logic fb;
  assign fb = ^(state_o & TAPS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      state_o <= INIT;
    else if (load_i)  state_o <= (seed_i == '0) ? INIT : seed_i;
    else if (adv_i)   state_o <= {state_o[W-2:0], fb};
  end
endmodule

// File: rtl/tpdf_source.sv
module tpdf_source
  import dither_requant_pkg::*;
#(
  parameter int unsigned FRAC_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    load_i,
  input  logic [GEN_W-1:0]        seed_a_i,
  input  logic [GEN_W-1:0]        seed_b_i,
  input  logic                    adv_i,
  output logic signed [FRAC_W:0]  dither_o,
  output logic [GEN_W-1:0]        state_a_o,
  output logic [GEN_W-1:0]        state_b_o
);
  localparam int unsigned CW = FRAC_W;
  localparam logic signed [CW-1:0] CENTRE = CW'(1 << (FRAC_W - 2));

  logic [N_GEN-1:0][GEN_W-1:0] seeds, states;
  logic signed [N_GEN-1:0][CW-1:0] comp;

  assign seeds = {seed_b_i, seed_a_i};

  for (genvar g = 0; g < N_GEN; g++) begin : g_gen
    prng_shift #(.W(GEN_W), .TAPS(GEN_TAPS[g]), .INIT(GEN_INIT[g])) u_prng (
      .clk_i, .rst_ni, .load_i, .seed_i(seeds[g]), .adv_i, .state_o(states[g])
    );
    // half output LSB span, centred on zero
    assign comp[g] = $signed({1'b0, states[g][FRAC_W-1:1]}) - CENTRE;
  end

  assign dither_o  = (FRAC_W+1)'($signed(comp[0])) + (FRAC_W+1)'($signed(comp[1]));
  assign state_a_o = states[0];
  assign state_b_o = states[1];
endmodule

// File: rtl/round_sat.sv
module round_sat #(
  parameter int unsigned IN_W  = 24,
  parameter int unsigned OUT_W = 16
) (
  input  logic signed [IN_W-1:0]        x_i,
  input  logic signed [IN_W-OUT_W:0]    d_i,
  input  logic                          en_i,
  output logic signed [OUT_W-1:0]       y_o
);
  localparam int unsigned FRAC_W = IN_W - OUT_W;
  localparam int unsigned SW = IN_W + 2;
  localparam logic signed [SW-1:0] HALF = SW'(1 << (FRAC_W - 1));
  localparam logic signed [SW-1:0] QMAX = SW'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [SW-1:0] QMIN = -SW'(1 << (OUT_W - 1));

  logic signed [SW-1:0] sum, q;

  always_comb begin
    sum = SW'(x_i) + (en_i ? SW'(d_i) : '0) + HALF;
    q   = sum >>> FRAC_W;
    if (q > QMAX)      y_o = QMAX[OUT_W-1:0];
    else if (q < QMIN) y_o = QMIN[OUT_W-1:0];
    else               y_o = q[OUT_W-1:0];
  end
endmodule

// File: rtl/dither_requant.sv
module dither_requant
  import dither_requant_pkg::*;
#(
  parameter int unsigned IN_W  = 24,
  parameter int unsigned OUT_W = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    in_valid_i,
  output logic                    in_ready_o,
  input  logic signed [IN_W-1:0]  in_data_i,
  input  logic                    dither_en_i,
  input  logic                    seed_load_i,
  input  logic [GEN_W-1:0]        seed_a_i,
  input  logic [GEN_W-1:0]        seed_b_i,
  output logic                    out_valid_o,
  output logic signed [OUT_W-1:0] out_data_o
);
  localparam int unsigned FRAC_W = IN_W - OUT_W;

  logic                    accept;
  logic signed [FRAC_W:0]  dither;
  logic signed [OUT_W-1:0] reduced;
  logic [GEN_W-1:0]        gen_a_st, gen_b_st;

  assign in_ready_o = ~seed_load_i;
  assign accept     = in_valid_i & in_ready_o;

  tpdf_source #(.FRAC_W(FRAC_W)) u_src (
    .clk_i, .rst_ni, .load_i(seed_load_i), .seed_a_i, .seed_b_i,
    .adv_i(accept), .dither_o(dither), .state_a_o(gen_a_st), .state_b_o(gen_b_st)
  );

  round_sat #(.IN_W(IN_W), .OUT_W(OUT_W)) u_rs (
    .x_i(in_data_i), .d_i(dither), .en_i(dither_en_i), .y_o(reduced)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
    end else begin
      out_valid_o <= accept;
      if (accept) out_data_o <= reduced;
    end
  end
endmodule

// File: rtl/dither_requant_chk.sv
module dither_requant_chk #(
  parameter int unsigned IN_W  = 24,
  parameter int unsigned OUT_W = 16
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    in_valid_i,
  input logic                    in_ready_o,
  input logic signed [IN_W-1:0]  in_data_i,
  input logic                    dither_en_i,
  input logic                    seed_load_i,
  input logic                    out_valid_o,
  input logic signed [OUT_W-1:0] out_data_o,
  input logic [31:0]             gen_a_st,
  input logic [31:0]             gen_b_st
);
  localparam int unsigned FRAC_W = IN_W - OUT_W;
  localparam longint QMAX = (64'sd1 <<< (OUT_W - 1)) - 1;
  localparam longint QMIN = -(64'sd1 <<< (OUT_W - 1));

  function automatic logic signed [OUT_W-1:0] clip(longint v);
    if (v > QMAX) return OUT_W'(QMAX);
    if (v < QMIN) return OUT_W'(QMIN);
    return OUT_W'(v);
  endfunction

  logic acc;
  assign acc = in_valid_i & in_ready_o;

  // R2
  ready_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_load_i |-> !in_ready_o);
  // R2
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> out_valid_o);
  // R2
  valid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc |=> !out_valid_o);
  // R3
  plain_round_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !dither_en_i) |=>
      out_data_o == clip((longint'($past(in_data_i)) + (64'sd1 <<< (FRAC_W-1))) >>> FRAC_W));
  // R10
  dither_bracket_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && dither_en_i) |=>
      (out_data_o == clip(longint'($past(in_data_i)) >>> FRAC_W)) ||
      (out_data_o == clip((longint'($past(in_data_i)) >>> FRAC_W) + 1)));
  // R9
  gen_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!acc && !seed_load_i) |=> ($stable(gen_a_st) && $stable(gen_b_st)));
  // R8
  gen_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gen_a_st != '0) && (gen_b_st != '0));
endmodule

bind dither_requant dither_requant_chk #(.IN_W(IN_W), .OUT_W(OUT_W)) u_chk (
  .clk_i, .rst_ni, .in_valid_i, .in_ready_o, .in_data_i, .dither_en_i,
  .seed_load_i, .out_valid_o, .out_data_o, .gen_a_st, .gen_b_st
);

// File: tb/tb_dither_requant.sv
module tb_dither_requant;
  logic clk = 0;
  logic rst_n = 0;
  logic in_valid = 0, dither_en = 0, seed_load = 0;
  logic signed [23:0] in_data = '0;
  logic [31:0] seed_a = '0, seed_b = '0;
  logic in_ready, out_valid;
  logic signed [15:0] out_data;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] ma, mb;

  always #2.5 clk = ~clk;

  dither_requant dut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_data_i(in_data), .dither_en_i(dither_en), .seed_load_i(seed_load),
    .seed_a_i(seed_a), .seed_b_i(seed_b), .out_valid_o(out_valid), .out_data_o(out_data)
  );

  function automatic logic [31:0] step_a(logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction
  function automatic logic [31:0] step_b(logic [31:0] s);
    return {s[30:0], s[31] ^ s[6] ^ s[4] ^ s[2] ^ s[1] ^ s[0]};
  endfunction
  function automatic longint comp(logic [31:0] s);
    return longint'(s[7:1]) - 64;
  endfunction
  function automatic logic signed [15:0] sat(longint v);
    if (v > 32767) return 16'sh7FFF;
    if (v < -32768) return -16'sh8000;
    return 16'(v);
  endfunction

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive one sample at a falling edge, check it one cycle later
  task automatic sample(logic signed [23:0] x, bit en, string req);
    longint v;
    logic signed [15:0] e;
    v = longint'(x) + 128 + (en ? comp(ma) + comp(mb) : 0);
    e = sat(v >>> 8);
    ma = step_a(ma);
    mb = step_b(mb);
    in_valid = 1; in_data = x; dither_en = en;
    @(negedge clk);
    in_valid = 0;
    check({req, " valid"}, out_valid, 1);
    check(req, out_data, e);
  endtask

  task automatic load(logic [31:0] a, logic [31:0] b);
    seed_load = 1; seed_a = a; seed_b = b; in_valid = 1;
    #1 check("R2 ready low during load", in_ready, 0);
    @(negedge clk);
    seed_load = 0; in_valid = 0;
    check("R2 no output on load cycle", out_valid, 0);
    ma = (a == 0) ? 32'h0000_0001 : a;
    mb = (b == 0) ? 32'h2545_F491 : b;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    ma = 32'h0000_0001; mb = 32'h2545_F491;
    repeat (3) @(negedge clk);
    check("R1 valid in reset", out_valid, 0);
    check("R1 data in reset", out_data, 0);
    rst_n = 1;
    @(negedge clk);
    check("R2 ready idle", in_ready, 1);
    check("R2 idle valid", out_valid, 0);

    // R1 reset seeds feed first dithered words (R5 R6 R7)
    for (int i = 0; i < 64; i++) sample(24'(i * 4099 - 100000), 1, "R1 R5 R6 R7 first");

    // R3 plain rounding over full range
    for (int i = 0; i < 50686; i++) sample(24'(-8388608 + i * 331), 0, "R3 sweep");
    // R3 around rounding midpoints
    for (int k = -3; k <= 3; k++)
      for (int j = 124; j <= 132; j++) sample(24'(k * 256 + j), 0, "R3 midpoint");
    // R4 saturation limits
    for (int j = 0; j < 200; j++) sample(24'(8388607 - j), 0, "R4 top");
    for (int j = 0; j < 200; j++) sample(24'(-8388608 + j), 0, "R4 bottom");
    sample(24'h7FFFFF, 0, "R4 max");
    sample(24'h7FFFFF, 1, "R4 max dithered");
    sample(24'sh800000, 1, "R4 min dithered");

    // R5 R6 R7 R10 dithered sweep
    for (int i = 0; i < 16272; i++) sample(24'(-8388608 + i * 1031), 1, "R5 R6 R7 R10 sweep");
    // fixed input: each output must bracket, counts both codes
    begin
      int lo = 0, hi = 0;
      for (int i = 0; i < 512; i++) begin
        sample(24'sd1000, 1, "R5 R10 fixed");
        if (out_data == 3) lo++;
        if (out_data == 4) hi++;
      end
      check("R10 bracket codes", lo + hi, 512);
      check("R5 both codes seen", (lo > 0 && hi > 0), 1);
    end

    // R9 stall leaves generators untouched
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      check("R2 R9 stall no valid", out_valid, 0);
    end
    for (int i = 0; i < 32; i++) sample(24'(i * 77 - 1000), 1, "R9 after stall");

    // R8 seed loads
    load(32'h1234_5678, 32'h9ABC_DEF0);
    for (int i = 0; i < 64; i++) sample(24'(i * 991), 1, "R8 seeded");
    load(32'h0, 32'h0);
    for (int i = 0; i < 64; i++) sample(24'(-i * 613), 1, "R8 zero seed");
    load(32'h0, 32'h0000_00FF);
    for (int i = 0; i < 64; i++) sample(24'(i * 31), 1, "R8 mixed seed");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule